// File: doc/BRIEF.md
# Randomized Equal-Weight Element Selector

This block drives seven identical 1-bit converter elements from a 3-bit level. On each accepted sample it asserts exactly as many element controls as the level asks for. Which elements carry the ones is picked afresh every sample by a pseudo-random permutation, so that any mismatch between the elements becomes uncorrelated noise instead of a distortion pattern tied to the input.

The permutation is drawn by a shuffle network. An internal maximal-length shift register supplies fresh random bits every clock, and a seed can be loaded during reset so that a run can be repeated. The pattern is registered and appears one clock after a valid level. When valid is low the previous pattern is held.

Top module: `dem_encoder`

## Requirements
- R1: One clock after a cycle with `valid_i` high, the number of ones on `dem_out_o` equals the `level_i` value sampled in that cycle.
- R2: Level 0 drives every bit of `dem_out_o` to 0.
- R3: Level 7 drives every bit of `dem_out_o` to 1.
- R4: A cycle with `valid_i` low leaves `dem_out_o` unchanged in the next cycle.
- R5: While `rst_n` is low, `dem_out_o` is cleared to zero one clock later.
- R6: At level 6, each of the seven single-zero patterns (the zero at bit 0 through bit 6) occurs.
- R7: At any level k, each element is one in a fraction k/7 of samples, within 0.02 over 20000 samples.
- R8: The pattern sequence after reset depends only on the seed and the inputs. The same seed loaded twice (`seed_load_i` high while `rst_n` is low) gives the same sequence. An all-zero seed, or a reset with `seed_load_i` low, behaves as seed 64'h5DEECE66D0B1A7F3.
- R9: Successive choices are independent. At level 3, two consecutive patterns are equal in a fraction close to 1/35 of samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| level_i | input | 3 | Requested number of asserted elements, 0 to 7 |
| valid_i | input | 1 | Accept `level_i` this cycle |
| seed_i | input | 64 | Random generator seed |
| seed_load_i | input | 1 | Load `seed_i` while reset is active |
| dem_out_o | output | 7 | Registered element controls |

## Verification
The hardest property to show from the ports is that the choice is unbiased and carries no memory from one sample to the next. A single pattern says nothing about that. The bench therefore holds each level for long stretches with valid high and tallies per-element ones. It also counts repeated consecutive patterns and records which zero positions appear at level 6. Repeatability and the zero-seed substitution are checked by replaying identical stimulus after two resets and comparing the recorded sequences.

// File: rtl/dem_pkg.sv
// Shared constants for the element selector.
// Assumes a 64-bit maximal-length generator (x^64+x^63+x^61+x^60+1).
package dem_pkg;
    localparam int unsigned          LFSR_W       = 64;
    localparam logic [LFSR_W-1:0]    LFSR_TAPS    = 64'hD800_0000_0000_0000;
    localparam logic [LFSR_W-1:0]    DEFAULT_SEED = 64'h5DEE_CE66_D0B1_A7F3;
endpackage

// File: rtl/dem_lfsr.sv
// Leaping Fibonacci shift register: advances LFSR_W steps per clock, so every
// state bit is fresh each cycle. Seed is taken during reset; zero is replaced.
// Assumes OUT_W <= LFSR_W.
module dem_lfsr #(
    parameter int unsigned       LFSR_W  = 64,
    parameter logic [LFSR_W-1:0] TAPS    = '0,
    parameter logic [LFSR_W-1:0] DEF_SD  = '1,
    parameter int unsigned       OUT_W   = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LFSR_W-1:0] seed_i,
    input  logic              seed_load_i,
    output logic [OUT_W-1:0]  rand_o
);
    logic [LFSR_W-1:0] state_q;
    logic [LFSR_W-1:0] state_d;

    // Purpose: compute the state LFSR_W single steps ahead.
    always_comb begin
        state_d = state_q;
        for (int s = 0; s < int'(LFSR_W); s++) begin
            state_d = {state_d[LFSR_W-2:0], ^(state_d & TAPS)};
        end
    end

    // Purpose: seed during reset, otherwise leap forward every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (seed_load_i && (seed_i != '0)) state_q <= seed_i;
            else                               state_q <= DEF_SD;
        end else begin
            state_q <= state_d;
        end
    end

    assign rand_o = state_q[OUT_W-1:0];
endmodule

// File: rtl/dem_shuffle.sv
// Combinational shuffle: Fisher-Yates permutation of N_ELEM positions using
// multiply-shift reduction of RAND_W-bit chunks, then maps the thermometer
// code of level_i through the permutation. Assumes RAND_W >> log2(N_ELEM).
module dem_shuffle #(
    parameter int unsigned N_ELEM = 7,
    parameter int unsigned RAND_W = 10,
    localparam int unsigned LEVEL_W = $clog2(N_ELEM + 1),
    localparam int unsigned IDX_W   = $clog2(N_ELEM),
    localparam int unsigned RBITS   = (N_ELEM - 1) * RAND_W
) (
    input  logic [RBITS-1:0]   rand_i,
    input  logic [LEVEL_W-1:0] level_i,
    output logic [N_ELEM-1:0]  pat_o
);
    localparam int unsigned PROD_W = RAND_W + LEVEL_W;

    logic [IDX_W-1:0] perm [N_ELEM];

    // Purpose: build the permutation from the random chunks.
    always_comb begin
        logic [RAND_W-1:0] chunk;
        logic [PROD_W-1:0] prod;
        logic [IDX_W-1:0]  j;
        logic [IDX_W-1:0]  tmp;
        for (int k = 0; k < int'(N_ELEM); k++) perm[k] = IDX_W'(k);
        for (int i = int'(N_ELEM) - 1; i >= 1; i--) begin
            chunk   = rand_i[(i-1)*int'(RAND_W) +: RAND_W];
            prod    = PROD_W'(chunk) * PROD_W'(i + 1);
            j       = IDX_W'(prod >> RAND_W);
            tmp     = perm[i];
            perm[i] = perm[j];
            perm[j] = tmp;
        end
    end

    // Purpose: route the first level_i permuted slots to ones.
    always_comb begin
        pat_o = '0;
        for (int k = 0; k < int'(N_ELEM); k++) begin
            if (k < int'(level_i)) pat_o[perm[k]] = 1'b1;
        end
    end
endmodule

// File: rtl/dem_encoder.sv
// Top: registered equal-weight element selector. Output updates one clock
// after valid_i; held otherwise; cleared in reset.
module dem_encoder #(
    parameter int unsigned N_ELEM = 7,
    parameter int unsigned RAND_W = 10,
    localparam int unsigned LEVEL_W = $clog2(N_ELEM + 1),
    localparam int unsigned RBITS   = (N_ELEM - 1) * RAND_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LEVEL_W-1:0]        level_i,
    input  logic                      valid_i,
    input  logic [dem_pkg::LFSR_W-1:0] seed_i,
    input  logic                      seed_load_i,
    output logic [N_ELEM-1:0]         dem_out_o
);
    logic [RBITS-1:0]  rnd;
    logic [N_ELEM-1:0] pat;

    dem_lfsr #(
        .LFSR_W (dem_pkg::LFSR_W),
        .TAPS   (dem_pkg::LFSR_TAPS),
        .DEF_SD (dem_pkg::DEFAULT_SEED),
        .OUT_W  (RBITS)
    ) u_lfsr (
        .clk         (clk),
        .rst_n       (rst_n),
        .seed_i      (seed_i),
        .seed_load_i (seed_load_i),
        .rand_o      (rnd)
    );

    dem_shuffle #(.N_ELEM(N_ELEM), .RAND_W(RAND_W)) u_shuf (
        .rand_i  (rnd),
        .level_i (level_i),
        .pat_o   (pat)
    );

    // Purpose: register the chosen pattern on valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       dem_out_o <= '0;
        else if (valid_i) dem_out_o <= pat;
    end
endmodule

// File: rtl/dem_encoder_chk.sv
// Checker for dem_encoder, attached by bind below.
module dem_encoder_chk #(
    parameter int unsigned N_ELEM = 7,
    localparam int unsigned LEVEL_W = $clog2(N_ELEM + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [LEVEL_W-1:0] level_i,
    input logic               valid_i,
    input logic [N_ELEM-1:0]  dem_out_o
);
    p_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> ($countones(dem_out_o) == int'($past(level_i))));
    p_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && level_i == '0) |=> (dem_out_o == '0));
    p_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && int'(level_i) == int'(N_ELEM)) |=> (dem_out_o == '1));
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(dem_out_o));
    p_clear_r5: assert property (@(posedge clk)
        !rst_n |=> (dem_out_o == '0));
endmodule

bind dem_encoder dem_encoder_chk #(.N_ELEM(N_ELEM)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .level_i   (level_i),
    .valid_i   (valid_i),
    .dem_out_o (dem_out_o)
);

// File: tb/dem_encoder_test.sv
module dem_encoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  level_i = '0;
    logic        valid_i = 1'b0;
    logic [63:0] seed_i = '0;
    logic        seed_load_i = 1'b0;
    logic [6:0]  dem_out_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    dem_encoder uut (
        .clk(clk), .rst_n(rst_n), .level_i(level_i), .valid_i(valid_i),
        .seed_i(seed_i), .seed_load_i(seed_load_i), .dem_out_o(dem_out_o)
    );

    always #5 clk = ~clk;

    // {valid, level[2:0], expected popcount[3:0]}
    localparam logic [7:0] VEC [12] = '{
        8'b1_000_0000, 8'b1_111_0111, 8'b1_011_0011, 8'b0_110_0011,
        8'b1_001_0001, 8'b1_110_0110, 8'b0_000_0110, 8'b1_100_0100,
        8'b1_010_0010, 8'b1_101_0101, 8'b0_111_0101, 8'b1_111_0111
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [63:0] sd, input bit ld);
        rst_n = 1'b0; valid_i = 1'b0; seed_i = sd; seed_load_i = ld;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; seed_load_i = 1'b0;
    endtask

    task automatic record(output logic [6:0] seq [16]);
        for (int n = 0; n < 16; n++) begin
            valid_i = 1'b1; level_i = 3'd3;
            @(negedge clk);
            seq[n] = dem_out_o;
        end
        valid_i = 1'b0;
    endtask

    function automatic bit seq_eq(input logic [6:0] a [16], input logic [6:0] b [16]);
        for (int n = 0; n < 16; n++) if (a[n] !== b[n]) return 1'b0;
        return 1'b1;
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [6:0] sa [16];
        logic [6:0] sb [16];
        logic [6:0] prev;
        logic [6:0] held;
        int cnt [7];
        int same;
        logic [6:0] seen;
        int lim;

        // R5: reset clears output
        @(negedge clk); @(negedge clk);
        chk(dem_out_o == 7'd0, "R5", int'(dem_out_o), 0);
        rst_n = 1'b1;

        // Vector table: R1 popcount, R2/R3 extremes, R4 hold
        held = dem_out_o;
        for (int v = 0; v < 12; v++) begin
            valid_i = VEC[v][7]; level_i = VEC[v][6:4];
            @(negedge clk);
            chk($countones(dem_out_o) == int'(VEC[v][3:0]), "R1",
                $countones(dem_out_o), int'(VEC[v][3:0]));
            if (VEC[v][7] && VEC[v][6:4] == 3'd0)
                chk(dem_out_o == 7'h00, "R2", int'(dem_out_o), 0);
            if (VEC[v][7] && VEC[v][6:4] == 3'd7)
                chk(dem_out_o == 7'h7F, "R3", int'(dem_out_o), 127);
            if (!VEC[v][7])
                chk(dem_out_o == held, "R4", int'(dem_out_o), int'(held));
            held = dem_out_o;
        end

        // R5: reset in mid-run clears output
        rst_n = 1'b0; @(negedge clk);
        chk(dem_out_o == 7'd0, "R5", int'(dem_out_o), 0);
        rst_n = 1'b1;

        // R8: repeatable with same seed; zero seed and no load act as default
        do_reset(64'h0123_4567_89AB_CDEF, 1'b1); record(sa);
        do_reset(64'h0123_4567_89AB_CDEF, 1'b1); record(sb);
        chk(seq_eq(sa, sb), "R8", int'(sb[15]), int'(sa[15]));
        do_reset(64'h5DEE_CE66_D0B1_A7F3, 1'b1); record(sa);
        do_reset(64'h0, 1'b1); record(sb);
        chk(seq_eq(sa, sb), "R8", int'(sb[15]), int'(sa[15]));
        do_reset(64'hFFFF_0000_FFFF_0000, 1'b0); record(sb);
        chk(seq_eq(sa, sb), "R8", int'(sb[15]), int'(sa[15]));
        same = 0;
        for (int n = 1; n < 16; n++) if (sb[n] == sb[0]) same++;
        chk(same < 15, "R8", same, 0);

        // R7 per-element frequency, R6 reachability, R9 independence
        for (int lev = 1; lev <= 6; lev++) begin
            for (int e = 0; e < 7; e++) cnt[e] = 0;
            same = 0; seen = '0; prev = '0;
            valid_i = 1'b1; level_i = 3'(lev);
            for (int n = 0; n < 20000; n++) begin
                @(negedge clk);
                for (int e = 0; e < 7; e++) if (dem_out_o[e]) cnt[e]++;
                if (n > 0 && dem_out_o == prev) same++;
                if (lev == 6) seen = seen | ~dem_out_o;
                prev = dem_out_o;
            end
            for (int e = 0; e < 7; e++) begin
                lim = 2800; // 0.02 * 7 * 20000
                chk((cnt[e] * 7 - lev * 20000) <= lim && (lev * 20000 - cnt[e] * 7) <= lim,
                    "R7", cnt[e], lev * 20000 / 7);
            end
            if (lev == 6) chk(seen == 7'h7F, "R6", int'(seen), 127);
            if (lev == 3) chk(same >= 421 && same <= 721, "R9", same, 571);
        end
        valid_i = 1'b0;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule